// File: doc/BRIEF.md
# Diagnostic Loopback Path Controller

This block sits between a MAC's transmit and receive FIFOs and the network port. It decides where transmit data goes and where receive data comes from during diagnostic loopback. Two port types are supported: a parallel serial port and a Manchester-coded attachment port. On the Manchester port, one internal mode sends the data out through an attached Manchester encoder/decoder pair and takes the decoded result back. The codec and both FIFOs are outside the block and are reached through plain ports.

Loopback control inputs are sampled only while the transmitter is idle. The routing therefore stays fixed for the length of a frame. The full-duplex setting affects collision reporting in normal operation only, and is disregarded during any loopback mode. In internal modes the network pins are silenced, the pin inputs are disregarded, and the MAC sees no collision.

Top module: `lb_path_ctrl`

## Requirements
- R1: While `rst` is high, and afterwards until a new setting is sampled, the block routes as in normal operation (R2).
- R2: With `loop_en`=0, the block works in normal operation. `pin_tx_data`=`tx_data`, `pin_tx_en`=`tx_vld`, `rxf_data`/`rxf_vld` follow `pin_rx_data`/`pin_rx_vld`, and `mac_col`=`pin_col` AND NOT `fdx_en`.
- R3: In external loopback, `fdx_en` has no effect: `mac_col` follows `pin_col` whatever the value of `fdx_en`.
- R4: Parallel port (`port_sel`=0) with `loop_en`=1 and `int_sel`=1: `rxf_data`/`rxf_vld` equal `tx_data`/`tx_vld`, `pin_tx_en`=0 and `pin_tx_data`=0, and the pin inputs have no effect on any output.
- R5: On the parallel port, `byp_sel` has no effect: internal loopback is always the direct path of R4.
- R6: Manchester port (`port_sel`=1) with `loop_en`, `int_sel` and `byp_sel` all 1: direct path as in R4, with the transmitter disabled and the pin inputs disregarded.
- R7: Manchester port with `loop_en`=1, `int_sel`=1 and `byp_sel`=0: `enc_data`/`enc_vld` equal `tx_data`/`tx_vld`, `rxf_data`/`rxf_vld` equal `dec_data`/`dec_vld`, `pin_tx_en`=0, and the pin inputs are disregarded.
- R8: With `loop_en`=1 and `int_sel`=0 (external loopback, on either port), transmit data goes to the pins, receive data comes from the pins, and `pin_col` reaches `mac_col`. `byp_sel` has no effect.
- R9: In both internal modes, `mac_col` is 0.
- R10: Control inputs are sampled at a clock edge only when `tx_vld` is 0 at that edge. The new routing applies from the following cycle. While `tx_vld` stays 1, control changes have no effect.
- R11: Outside the codec mode of R7, `enc_vld`=0 and `enc_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | Loopback enable |
| int_sel | input | 1 | 1 = internal loopback, 0 = external |
| byp_sel | input | 1 | 1 = internal loop skips the Manchester codec |
| port_sel | input | 1 | 0 = parallel serial port, 1 = Manchester port |
| fdx_en | input | 1 | Full-duplex setting |
| tx_data | input | DW | Beat from the transmit FIFO |
| tx_vld | input | 1 | Transmit beat valid; high for the whole frame |
| pin_rx_data | input | DW | Receive beat from the network pins |
| pin_rx_vld | input | 1 | Pin receive beat valid |
| pin_col | input | 1 | Collision from the network pins |
| dec_data | input | DW | Beat from the Manchester decoder |
| dec_vld | input | 1 | Decoder beat valid |
| rxf_data | output | DW | Beat to the receive FIFO |
| rxf_vld | output | 1 | Receive FIFO beat valid |
| pin_tx_data | output | DW | Transmit beat to the network pins |
| pin_tx_en | output | 1 | Pin transmitter enable |
| enc_data | output | DW | Beat to the Manchester encoder |
| enc_vld | output | 1 | Encoder beat valid |
| mac_col | output | 1 | Collision indication to the MAC |

## Verification
The bench builds the block with DW=4 and HAS_CODEC=1. This makes all four routings reachable, including the codec round trip, and uses nibble-wide data, so a wrong lane or a zero-forced bus shows up as a value mismatch. All 32 control combinations are applied in turn. The pin and decoder inputs carry unrelated random traffic, so any leak from a disregarded input is caught. The controls are also changed in the middle of frames, which exercises the idle-only sampling.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL     = 2'd0,
        LB_EXTERNAL   = 2'd1,
        LB_INT_DIRECT = 2'd2,
        LB_INT_CODEC  = 2'd3
    } lb_mode_e;

    typedef enum logic {
        PORT_PARALLEL = 1'b0,
        PORT_MANCH    = 1'b1
    } lb_port_e;

    // Raw control inputs as presented at the pins
    typedef struct packed {
        logic     loop_en;
        logic     int_sel;
        logic     byp_sel;
        lb_port_e port;
        logic     fdx;
    } lb_ctl_t;

    // Latched routing configuration
    typedef struct packed {
        lb_port_e port;
        lb_mode_e mode;
        logic     fdx;
    } lb_cfg_t;

    localparam lb_cfg_t LB_CFG_RESET = '{port: PORT_PARALLEL, mode: LB_NORMAL, fdx: 1'b0};

    function automatic lb_mode_e lb_decode(input lb_ctl_t c, input logic has_codec);
        lb_mode_e m;
        if (!c.loop_en)
            m = LB_NORMAL;
        else if (!c.int_sel)
            m = LB_EXTERNAL;
        else if (c.port == PORT_PARALLEL)
            m = LB_INT_DIRECT;
        else if (c.byp_sel || !has_codec)
            m = LB_INT_DIRECT;
        else
            m = LB_INT_CODEC;
        return m;
    endfunction

    function automatic logic lb_is_internal(input lb_mode_e m);
        return (m == LB_INT_DIRECT) || (m == LB_INT_CODEC);
    endfunction

endpackage

// File: rtl/lb_ctl_decode.sv
module lb_ctl_decode
    import lb_pkg::*;
#(
    parameter bit HAS_CODEC = 1'b1
) (
    input  lb_ctl_t ctl,
    output lb_cfg_t cfg_next
);
    always_comb begin
        cfg_next.port = ctl.port;
        cfg_next.mode = lb_decode(ctl, HAS_CODEC);
        cfg_next.fdx  = ctl.fdx;
    end
endmodule

// File: rtl/lb_cfg_hold.sv
module lb_cfg_hold
    import lb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tx_busy,
    input  lb_cfg_t cfg_next,
    output lb_cfg_t cfg_q
);
    // New routing is taken only between frames
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= LB_CFG_RESET;
        else if (!tx_busy)
            cfg_q <= cfg_next;
    end
endmodule

// File: rtl/lb_route.sv
module lb_route
    import lb_pkg::*;
#(
    parameter int DW        = 4,
    parameter bit HAS_CODEC = 1'b1
) (
    input  lb_cfg_t          cfg,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_vld,
    input  logic [DW-1:0]    pin_rx_data,
    input  logic             pin_rx_vld,
    input  logic             pin_col,
    input  logic [DW-1:0]    dec_data,
    input  logic             dec_vld,
    output logic [DW-1:0]    rxf_data,
    output logic             rxf_vld,
    output logic [DW-1:0]    pin_tx_data,
    output logic             pin_tx_en,
    output logic [DW-1:0]    enc_data,
    output logic             enc_vld,
    output logic             mac_col
);
    localparam logic [DW-1:0] ZERO = '0;

    logic          internal;
    logic          pins_live;
    logic [DW-1:0] loop_data;
    logic          loop_vld;

    assign internal  = lb_is_internal(cfg.mode);
    assign pins_live = !internal;

    // Transmit side: pins are silent in either internal mode
    assign pin_tx_data = pins_live ? tx_data : ZERO;
    assign pin_tx_en   = pins_live & tx_vld;

    // Collision: masked in internal modes; duplex mask only in normal mode
    always_comb begin
        unique case (cfg.mode)
            LB_NORMAL:   mac_col = pin_col & ~cfg.fdx;
            LB_EXTERNAL: mac_col = pin_col;
            default:     mac_col = 1'b0;
        endcase
    end

    generate
        if (HAS_CODEC) begin : g_codec
            logic via_codec;
            assign via_codec = (cfg.mode == LB_INT_CODEC);
            assign enc_data  = via_codec ? tx_data : ZERO;
            assign enc_vld   = via_codec & tx_vld;
            assign loop_data = via_codec ? dec_data : tx_data;
            assign loop_vld  = via_codec ? dec_vld  : tx_vld;
        end else begin : g_nocodec
            assign enc_data  = ZERO;
            assign enc_vld   = 1'b0;
            assign loop_data = tx_data;
            assign loop_vld  = tx_vld;
        end
    endgenerate

    // Receive side
    assign rxf_data = internal ? loop_data : pin_rx_data;
    assign rxf_vld  = internal ? loop_vld  : pin_rx_vld;
endmodule

// File: rtl/lb_path_ctrl.sv
module lb_path_ctrl
    import lb_pkg::*;
#(
    parameter int DW        = 4,
    parameter bit HAS_CODEC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loop_en,
    input  logic          int_sel,
    input  logic          byp_sel,
    input  logic          port_sel,
    input  logic          fdx_en,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_vld,
    input  logic [DW-1:0] pin_rx_data,
    input  logic          pin_rx_vld,
    input  logic          pin_col,
    input  logic [DW-1:0] dec_data,
    input  logic          dec_vld,
    output logic [DW-1:0] rxf_data,
    output logic          rxf_vld,
    output logic [DW-1:0] pin_tx_data,
    output logic          pin_tx_en,
    output logic [DW-1:0] enc_data,
    output logic          enc_vld,
    output logic          mac_col
);
    lb_ctl_t ctl;
    lb_cfg_t cfg_next;
    lb_cfg_t cfg_q;

    always_comb begin
        ctl.loop_en = loop_en;
        ctl.int_sel = int_sel;
        ctl.byp_sel = byp_sel;
        ctl.port    = lb_port_e'(port_sel);
        ctl.fdx     = fdx_en;
    end

    lb_ctl_decode #(.HAS_CODEC(HAS_CODEC)) u_dec (
        .ctl      (ctl),
        .cfg_next (cfg_next)
    );

    lb_cfg_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .tx_busy  (tx_vld),
        .cfg_next (cfg_next),
        .cfg_q    (cfg_q)
    );

    lb_route #(.DW(DW), .HAS_CODEC(HAS_CODEC)) u_route (
        .cfg         (cfg_q),
        .tx_data     (tx_data),
        .tx_vld      (tx_vld),
        .pin_rx_data (pin_rx_data),
        .pin_rx_vld  (pin_rx_vld),
        .pin_col     (pin_col),
        .dec_data    (dec_data),
        .dec_vld     (dec_vld),
        .rxf_data    (rxf_data),
        .rxf_vld     (rxf_vld),
        .pin_tx_data (pin_tx_data),
        .pin_tx_en   (pin_tx_en),
        .enc_data    (enc_data),
        .enc_vld     (enc_vld),
        .mac_col     (mac_col)
    );
endmodule

// File: rtl/lb_path_ctrl_chk.sv
module lb_path_ctrl_chk
    import lb_pkg::*;
#(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst,
    input lb_cfg_t       cfg,
    input logic [DW-1:0] tx_data,
    input logic          tx_vld,
    input logic [DW-1:0] rxf_data,
    input logic          rxf_vld,
    input logic [DW-1:0] pin_tx_data,
    input logic          pin_tx_en,
    input logic          enc_vld,
    input logic          mac_col
);
    logic intl;
    assign intl = (cfg.mode == LB_INT_DIRECT) || (cfg.mode == LB_INT_CODEC);

    // R10: routing frozen while a frame is in flight
    p_frame_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tx_vld)) |-> $stable(cfg));

    // R4 / R6 / R7: no transmission in internal modes
    p_int_pins_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        intl |-> (!pin_tx_en && pin_tx_data == '0));

    // R9: collision hidden in internal modes
    p_int_col_mask_r9: assert property (@(posedge clk) disable iff (rst)
        intl |-> !mac_col);

    // R6: direct path echoes transmit data
    p_direct_echo_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == LB_INT_DIRECT) |-> (rxf_data == tx_data && rxf_vld == tx_vld));

    // R11: encoder idle outside codec mode
    p_enc_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode != LB_INT_CODEC) |-> !enc_vld);

    // R5: parallel port never routes through the codec
    p_parallel_no_codec_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.port == PORT_PARALLEL) |-> (cfg.mode != LB_INT_CODEC));
endmodule

bind lb_path_ctrl lb_path_ctrl_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg_q),
    .tx_data     (tx_data),
    .tx_vld      (tx_vld),
    .rxf_data    (rxf_data),
    .rxf_vld     (rxf_vld),
    .pin_tx_data (pin_tx_data),
    .pin_tx_en   (pin_tx_en),
    .enc_vld     (enc_vld),
    .mac_col     (mac_col)
);

// File: tb/lb_path_ctrl_test.sv
`timescale 1ns/1ps
module lb_path_ctrl_test;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loop_en = 0, int_sel = 0, byp_sel = 0, port_sel = 0, fdx_en = 0;
    logic [DW-1:0] tx_data = '0, pin_rx_data = '0, dec_data = '0;
    logic tx_vld = 0, pin_rx_vld = 0, pin_col = 0, dec_vld = 0;
    logic [DW-1:0] rxf_data, pin_tx_data, enc_data;
    logic rxf_vld, pin_tx_en, enc_vld, mac_col;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lb_path_ctrl #(.DW(DW), .HAS_CODEC(1'b1)) uut (
        .clk(clk), .rst(rst), .loop_en(loop_en), .int_sel(int_sel),
        .byp_sel(byp_sel), .port_sel(port_sel), .fdx_en(fdx_en),
        .tx_data(tx_data), .tx_vld(tx_vld), .pin_rx_data(pin_rx_data),
        .pin_rx_vld(pin_rx_vld), .pin_col(pin_col), .dec_data(dec_data),
        .dec_vld(dec_vld), .rxf_data(rxf_data), .rxf_vld(rxf_vld),
        .pin_tx_data(pin_tx_data), .pin_tx_en(pin_tx_en),
        .enc_data(enc_data), .enc_vld(enc_vld), .mac_col(mac_col)
    );

    // Reference model: 0 normal, 1 external, 2 internal direct, 3 internal codec
    int  m_mode = 0;
    bit  m_port = 0, m_fdx = 0, m_byp = 0;
    bit  changed_mid = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 0; m_port <= 0; m_fdx <= 0; m_byp <= 0;
        end else if (!tx_vld) begin
            m_port <= port_sel; m_fdx <= fdx_en; m_byp <= byp_sel;
            if (!loop_en)          m_mode <= 0;
            else if (!int_sel)     m_mode <= 1;
            else if (!port_sel)    m_mode <= 2;
            else if (byp_sel)      m_mode <= 2;
            else                   m_mode <= 3;
        end
        if (!tx_vld) changed_mid <= 0;
    end

    function automatic string path_tag();
        if (rst)          return "R1";
        if (changed_mid)  return "R10";
        case (m_mode)
            0: return "R2";
            1: return m_fdx ? "R3" : "R8";
            2: return m_port ? "R6" : (m_byp ? "R5" : "R4");
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [DW-1:0] e_rxd, e_txd, e_encd;
            logic e_rxv, e_txe, e_encv, e_col;
            case (m_mode)
                0, 1: begin
                    e_rxd = pin_rx_data; e_rxv = pin_rx_vld;
                    e_txd = tx_data;     e_txe = tx_vld;
                    e_encd = '0;         e_encv = 0;
                    e_col = (m_mode == 1) ? pin_col : (pin_col & ~m_fdx);
                end
                2: begin
                    e_rxd = tx_data; e_rxv = tx_vld;
                    e_txd = '0; e_txe = 0; e_encd = '0; e_encv = 0; e_col = 0;
                end
                default: begin
                    e_rxd = dec_data; e_rxv = dec_vld;
                    e_txd = '0; e_txe = 0; e_encd = tx_data; e_encv = tx_vld; e_col = 0;
                end
            endcase
            check(path_tag(), "rx/tx path",
                  {6'd0, rxf_data, rxf_vld, pin_tx_data, pin_tx_en},
                  {6'd0, e_rxd, e_rxv, e_txd, e_txe});
            check((m_mode >= 2 && !rst && !changed_mid) ? "R9" : path_tag(), "mac_col",
                  {15'd0, mac_col}, {15'd0, e_col});
            check((m_mode == 3 || rst || changed_mid) ? path_tag() : "R11", "encoder",
                  {11'd0, enc_data, enc_vld}, {11'd0, e_encd, e_encv});
        end
    end

    task automatic randomize_pins();
        pin_rx_data = DW'($urandom); pin_rx_vld = 1'($urandom);
        pin_col = 1'($urandom);
        dec_data = DW'($urandom); dec_vld = 1'($urandom);
    endtask

    task automatic run_frame(input int cfg, input int len, input bit disturb);
        @(posedge clk); #1;
        {loop_en, int_sel, byp_sel, port_sel, fdx_en} = 5'(cfg);
        tx_vld = 0; randomize_pins();
        repeat (2) begin @(posedge clk); #1; randomize_pins(); end
        for (int i = 0; i < len; i++) begin
            tx_vld = 1; tx_data = DW'($urandom); randomize_pins();
            if (disturb && i == len / 2) begin
                {loop_en, int_sel, byp_sel, port_sel, fdx_en} = 5'($urandom);
                changed_mid = 1;
            end
            @(posedge clk); #1;
        end
        tx_vld = 0; tx_data = '0;
    endtask

    initial begin
        // R1: reset routing, pins active and normal
        pin_col = 1; pin_rx_data = 4'hA; pin_rx_vld = 1;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R2..R9, R11: every control combination, with frames
        for (int c = 0; c < 32; c++) begin
            run_frame(c, 6, 1'b0);
            run_frame(c, 8, 1'b1);   // R10: controls disturbed mid-frame
        end
        run_frame(5'b11010, 10, 1'b1);   // R7 codec loop, then disturbed
        run_frame(5'b11100, 10, 1'b0);   // R5: bypass on parallel port
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule